// File: doc/BRIEF.md
# Wide Status Register File

This block keeps the small set of 256-bit special registers that a big-number coprocessor datapath reads and writes beside its general register file. Two slots are plain storage: a modulus register and an accumulator register. A third slot passes data straight through from an external random-value unit, and raises a request towards that unit whenever the datapath reads it. The fourth code of the 2-bit index space selects no register.

Writes from the datapath do not change the visible contents at once. Each plain register keeps a staged value and a staged flag. A commit strobe moves every staged value into its register. An abort strobe throws every staged value away. Reads always return the committed contents. On the cycle after a commit that changed at least one register, a trace strobe and a per-register mask tell a tracing unit which registers took a new value. The reset input is asserted asynchronously and released through an internal two-stage synchronizer.

Top module: `wsr_file`

## Requirements
- R1: After reset, the modulus and accumulator registers read as zero and nothing is staged, so a commit with no earlier write leaves trace_mask_o at zero.
- R2: Index encoding: 0 selects the modulus register, 1 the random slot, 3 the accumulator. rd_valid_o is 1 for indices 0, 1 and 3, and 0 for index 2, where rd_data_o reads as zero.
- R3: A write to index 0 or 3 only stages a value. rd_data_o keeps returning the committed value until a commit is taken.
- R4: On a commit, each register with a staged value takes it and its staged flag clears. A register with nothing staged keeps its value.
- R5: An abort drops every staged value. No register changes, and a later commit with no new write changes nothing.
- R6: Writes to index 1 or index 2 are ignored: a later commit changes neither plain register and leaves trace_mask_o at zero.
- R7: A second write to the same register before a commit replaces the staged value. The commit applies the later value.
- R8: A write in the same cycle as a commit is included in that commit. A write in the same cycle as an abort is dropped. When commit and abort are both high, the abort wins and nothing is committed.
- R9: In the cycle after a commit, trace_mask_o bit 0 is set if the modulus register took a staged value and bit 1 if the accumulator did. In every other cycle both bits are zero. trace_vld_o is high exactly when either bit is set.
- R10: When rd_idx_i is 1, rd_data_o equals rnd_data_i in the same cycle. rnd_req_o is high exactly when rd_en_i is high and rd_idx_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously |
| wr_en_i | input | 1 | Write strobe from the datapath |
| wr_idx_i | input | 2 | Register index of the write |
| wr_data_i | input | 256 | Write data |
| commit_i | input | 1 | Make all staged writes architectural |
| abort_i | input | 1 | Discard all staged writes |
| rd_en_i | input | 1 | Read strobe from the datapath |
| rd_idx_i | input | 2 | Register index of the read |
| rd_data_o | output | 256 | Committed contents of the indexed register |
| rd_valid_o | output | 1 | Read index names an implemented register |
| rnd_data_i | input | 256 | Value offered by the random-value unit |
| rnd_req_o | output | 1 | Read of the random slot is in progress |
| trace_vld_o | output | 1 | A commit updated at least one register |
| trace_mask_o | output | 2 | Registers updated by the last commit (bit 0 modulus, bit 1 accumulator) |

## Verification
Staging and the two strobes meet in one cycle when a write arrives together with a commit or an abort, or when commit and abort are raised together. The bench drives each of these pairings on purpose, with and without a value already staged, and then continues with a long stretch of mixed random traffic that hits them again. Each case is judged by the register contents read back after the cycle and by the trace mask of the following cycle. Both are compared with a behavioural model that applies the write first and then the strobes, with abort taking precedence.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

  // Register index codes seen on the read and write index ports.
  typedef enum logic [1:0] {
    IDX_MOD  = 2'd0,
    IDX_RND  = 2'd1,
    IDX_HOLE = 2'd2,
    IDX_ACC  = 2'd3
  } wsr_idx_e;

  // Number of plain storage slots (modulus, accumulator).
  localparam int unsigned N_PLAIN = 2;

  // Maps a plain slot number to the index code that addresses it.
  function automatic wsr_idx_e slot_to_idx(input int unsigned slot);
    return (slot == 0) ? IDX_MOD : IDX_ACC;
  endfunction

endpackage

// File: rtl/wsr_rst_sync.sv
module wsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/wsr_slot.sv
module wsr_slot #(
  parameter int unsigned DATA_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              abort_i,
  output logic [DATA_W-1:0] q_o,
  output logic              pend_o,
  output logic              upd_o
);

  logic [DATA_W-1:0] val_q, val_d;
  logic [DATA_W-1:0] stg_q, stg_d;
  logic              pend_q, pend_d;
  logic              val_en, stg_en;
  logic              eff_pend;
  logic [DATA_W-1:0] eff_val;

  // Next state: a write in this cycle is folded in before the strobes act.
  always_comb begin
    eff_pend = wr_i | pend_q;
    eff_val  = wr_i ? wr_data_i : stg_q;
    upd_o    = commit_i & ~abort_i & eff_pend;
    val_en   = upd_o;
    val_d    = eff_val;
    stg_en   = wr_i & ~abort_i & ~commit_i;
    stg_d    = wr_data_i;
    if (abort_i || commit_i) begin
      pend_d = 1'b0;
    end else begin
      pend_d = eff_pend;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      stg_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (val_en) begin
        val_q <= val_d;
      end
      if (stg_en) begin
        stg_q <= stg_d;
      end
      pend_q <= pend_d;
    end
  end

  assign q_o    = val_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/wsr_read_mux.sv
module wsr_read_mux
  import wsr_pkg::*;
#(
  parameter int unsigned DATA_W = 256
) (
  input  logic [1:0]                      idx_i,
  input  logic [N_PLAIN-1:0][DATA_W-1:0]  slot_q_i,
  input  logic [DATA_W-1:0]               rnd_i,
  output logic [DATA_W-1:0]               data_o,
  output logic                            valid_o
);

  always_comb begin
    data_o  = '0;
    valid_o = 1'b1;
    case (wsr_idx_e'(idx_i))
      IDX_MOD: data_o = slot_q_i[0];
      IDX_RND: data_o = rnd_i;
      IDX_ACC: data_o = slot_q_i[1];
      default: valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/wsr_file.sv
module wsr_file
  import wsr_pkg::*;
#(
  parameter int unsigned DATA_W = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              abort_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  input  logic [DATA_W-1:0] rnd_data_i,
  output logic              rnd_req_o,
  output logic              trace_vld_o,
  output logic [1:0]        trace_mask_o
);

  logic                           rst_sync_n;
  logic [N_PLAIN-1:0][DATA_W-1:0] slot_q;
  logic [N_PLAIN-1:0]             slot_pend;
  logic [N_PLAIN-1:0]             slot_upd;
  logic [N_PLAIN-1:0]             slot_wr;
  logic [N_PLAIN-1:0]             trace_q, trace_d;

  wsr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  // One staged register per plain slot; random slot and hole get no storage.
  for (genvar s = 0; s < N_PLAIN; s++) begin : g_slot
    always_comb begin
      slot_wr[s] = wr_en_i && (wr_idx_i == slot_to_idx(s));
    end

    wsr_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .wr_i      (slot_wr[s]),
      .wr_data_i (wr_data_i),
      .commit_i  (commit_i),
      .abort_i   (abort_i),
      .q_o       (slot_q[s]),
      .pend_o    (slot_pend[s]),
      .upd_o     (slot_upd[s])
    );
  end

  wsr_read_mux #(.DATA_W(DATA_W)) u_mux (
    .idx_i    (rd_idx_i),
    .slot_q_i (slot_q),
    .rnd_i    (rnd_data_i),
    .data_o   (rd_data_o),
    .valid_o  (rd_valid_o)
  );

  always_comb begin
    rnd_req_o = rd_en_i && (wsr_idx_e'(rd_idx_i) == IDX_RND);
    trace_d   = slot_upd;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      trace_q <= '0;
    end else begin
      trace_q <= trace_d;
    end
  end

  assign trace_mask_o = trace_q;
  assign trace_vld_o  = |trace_q;

endmodule

// File: rtl/wsr_file_chk.sv
module wsr_file_chk #(
  parameter int unsigned DATA_W = 256
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    commit_i,
  input logic                    abort_i,
  input logic                    rd_en_i,
  input logic [1:0]              rd_idx_i,
  input logic                    rd_valid_o,
  input logic [DATA_W-1:0]       rd_data_o,
  input logic [DATA_W-1:0]       rnd_data_i,
  input logic                    rnd_req_o,
  input logic                    trace_vld_o,
  input logic [1:0][DATA_W-1:0]  slot_q,
  input logic [1:0]              slot_pend
);

  AST_HOLE_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == 2'd2) |-> (!rd_valid_o && rd_data_o == '0)); // R2

  AST_RND_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == 2'd1) |-> (rd_data_o == rnd_data_i && rnd_req_o == rd_en_i)); // R10

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i || abort_i) |=> $stable(slot_q)); // R3

  AST_ABORT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (slot_pend == 2'b00)); // R5

  AST_COMMIT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (slot_pend == 2'b00)); // R4

  AST_TRACE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_vld_o |-> $past(commit_i && !abort_i)); // R9

endmodule

bind wsr_file wsr_file_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .commit_i    (commit_i),
  .abort_i     (abort_i),
  .rd_en_i     (rd_en_i),
  .rd_idx_i    (rd_idx_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .rnd_data_i  (rnd_data_i),
  .rnd_req_o   (rnd_req_o),
  .trace_vld_o (trace_vld_o),
  .slot_q      (slot_q),
  .slot_pend   (slot_pend)
);

// File: tb/sim_wsr_file.sv
module sim_wsr_file;

  localparam int W = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_idx = '0;
  logic [W-1:0] wr_data = '0;
  logic         commit = 1'b0;
  logic         abort = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_idx = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid;
  logic [W-1:0] rnd_data = '0;
  logic         rnd_req;
  logic         trace_vld;
  logic [1:0]   trace_mask;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string phase = "R1";

  // Behavioural reference: slot 0 modulus, slot 1 accumulator.
  logic [W-1:0] m_val [2];
  logic [W-1:0] m_stg [2];
  bit           m_pend [2];
  logic [1:0]   m_trace;

  always #10 clk = ~clk;

  wsr_file #(.DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .commit_i(commit), .abort_i(abort),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .rnd_data_i(rnd_data), .rnd_req_o(rnd_req),
    .trace_vld_o(trace_vld), .trace_mask_o(trace_mask)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input logic [31:0] seed);
    logic [W-1:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = seed ^ (32'h9E3779B9 * (k + 1));
    return v;
  endfunction

  function automatic int slot_of(input logic [1:0] idx);
    if (idx == 2'd0) return 0;
    if (idx == 2'd3) return 1;
    return -1;
  endfunction

  // Compare all outputs against the model, then advance one clock.
  task automatic step(input bit we, input logic [1:0] wi, input logic [W-1:0] wd,
                      input bit cm, input bit ab, input bit re, input logic [1:0] ri);
    logic [W-1:0] exp_rd;
    int s;
    wr_en = we; wr_idx = wi; wr_data = wd; commit = cm; abort = ab;
    rd_en = re; rd_idx = ri;
    rnd_data = pat($urandom);
    #2;
    case (ri)
      2'd0: exp_rd = m_val[0];
      2'd1: exp_rd = rnd_data;
      2'd3: exp_rd = m_val[1];
      default: exp_rd = '0;
    endcase
    check(rd_data === exp_rd, phase, rd_data, exp_rd);
    check(rd_valid === (ri != 2'd2), "R2", W'(rd_valid), W'(ri != 2'd2));
    check(rnd_req === (re && ri == 2'd1), "R10", W'(rnd_req), W'(re && ri == 2'd1));
    check(trace_mask === m_trace, "R9", W'(trace_mask), W'(m_trace));
    check(trace_vld === (|m_trace), "R9", W'(trace_vld), W'(|m_trace));
    @(posedge clk);
    // Model: write folded in first, abort beats commit.
    s = we ? slot_of(wi) : -1;
    m_trace = '0;
    if (ab) begin
      m_pend[0] = 0; m_pend[1] = 0;
    end else begin
      if (s >= 0) begin m_stg[s] = wd; m_pend[s] = 1; end
      if (cm) begin
        for (int k = 0; k < 2; k++) begin
          if (m_pend[k]) begin
            m_val[k] = m_stg[k];
            m_trace[k] = 1'b1;
          end
          m_pend[k] = 0;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input logic [1:0] ri);
    step(0, 2'd0, '0, 0, 0, 1, ri);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin m_val[k] = '0; m_stg[k] = '0; m_pend[k] = 0; end
    m_trace = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset contents and empty staging
    phase = "R1";
    idle(2'd0); idle(2'd3);
    step(0, 2'd0, '0, 1, 0, 0, 2'd0);
    idle(2'd0);

    // R2 / R10: index map, hole, random pass-through with and without strobe
    phase = "R2";
    for (int i = 0; i < 4; i++) idle(2'(i));
    phase = "R10";
    step(0, 2'd0, '0, 0, 0, 0, 2'd1);
    step(0, 2'd0, '0, 0, 0, 1, 2'd1);

    // R3: staged write invisible until commit
    phase = "R3";
    step(1, 2'd0, pat(32'h11), 0, 0, 1, 2'd0);
    idle(2'd0); idle(2'd0);
    // R4: commit applies, untouched register unchanged
    phase = "R4";
    step(0, 2'd0, '0, 1, 0, 1, 2'd0);
    idle(2'd0);
    step(1, 2'd3, pat(32'h22), 0, 0, 1, 2'd3);
    step(0, 2'd0, '0, 1, 0, 1, 2'd0);
    idle(2'd0); idle(2'd3);

    // R5: abort discards staged value
    phase = "R5";
    step(1, 2'd0, pat(32'h33), 0, 0, 1, 2'd0);
    step(0, 2'd0, '0, 0, 1, 1, 2'd0);
    step(0, 2'd0, '0, 1, 0, 1, 2'd0);
    idle(2'd0);

    // R6: writes to random slot and hole are ignored
    phase = "R6";
    step(1, 2'd1, pat(32'h44), 0, 0, 1, 2'd0);
    step(1, 2'd2, pat(32'h55), 0, 0, 1, 2'd3);
    step(0, 2'd0, '0, 1, 0, 1, 2'd0);
    idle(2'd3); idle(2'd0);

    // R7: later write replaces staged value
    phase = "R7";
    step(1, 2'd3, pat(32'h66), 0, 0, 1, 2'd3);
    step(1, 2'd3, pat(32'h77), 0, 0, 1, 2'd3);
    step(0, 2'd0, '0, 1, 0, 1, 2'd3);
    idle(2'd3);

    // R8: write with commit, write with abort, commit with abort
    phase = "R8";
    step(1, 2'd0, pat(32'h88), 1, 0, 1, 2'd0);
    idle(2'd0);
    step(1, 2'd3, pat(32'h99), 0, 1, 1, 2'd3);
    step(0, 2'd0, '0, 1, 0, 1, 2'd3);
    step(1, 2'd0, pat(32'hAA), 0, 0, 1, 2'd0);
    step(1, 2'd3, pat(32'hBB), 1, 1, 1, 2'd3);
    step(0, 2'd0, '0, 1, 0, 1, 2'd0);
    idle(2'd3);

    // Mixed traffic
    for (int n = 0; n < 400; n++) begin
      step(1'($urandom), 2'($urandom), pat($urandom), ($urandom % 4) == 0,
           ($urandom % 6) == 0, 1'($urandom), 2'($urandom));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule